// File: doc/BRIEF.md
# Single-Bus Microcoded Processor

A small 32-bit processor in which every transfer between storage elements crosses one shared internal bus. The program counter, memory address latch, memory data latch, instruction latch, a 32-entry register file, an ALU operand latch (`Y`) and an ALU result latch (`Z`) all hang off that bus. A sequencer built as an enumerated state machine emits one control word per clock. Each control word selects exactly one bus source, the latches that load from the bus, the ALU operation, the register field to use, and the memory strobes.

Every instruction starts with a shared fetch sequence. Fetch runs through `S_F0` (PC to bus, MAR load, read strobe, Y load), then `S_F1` (Z = Y + 4, held until the memory raises its completion flag), then `S_F2` (MDR to IR), then `S_F3` (Z to PC, then dispatch). `S_F3` decodes the opcode and jumps to one of six routines. Add-immediate runs `S_A0`→`S_A1`→`S_A2`. Xor-immediate runs `S_X0`→`S_X1`→`S_X2`. The PC-relative branch runs `S_B0`→`S_B1`→`S_B2`. Store-one runs `S_O0`…`S_O4`. Average runs `S_V0`…`S_V7`. The register/memory exchange runs `S_E0`→`S_E1` (waits for completion)→`S_E2`→`S_E3`→`S_E4`. The last state of each routine returns to `S_F0`. Any other opcode sends `S_F3` to `S_HALT`, which never exits.

Memory lives outside the block. The block presents a byte address together with a read or write strobe. A read completes when the memory raises `mem_done`, a level that stays high until the next read strobe. Write data is taken in the strobe cycle.

Top module: `cpu_top`

## Requirements
- R1: After reset the PC reads 0, `halted` is low, and the first cycle after reset drives `mem_rd` with `mem_addr` = 0.
- R2: Fetch takes 3 cycles plus the cycles spent waiting for `mem_done`. With a memory that raises `mem_done` 8 cycles after the read-strobe cycle, an instruction's routine begins 11 cycles after its fetch began.
- R3: Opcode is bits 31:26, rs bits 25:21, rt bits 20:16, rd bits 15:11, immediate bits 15:0. An opcode other than 1, 2, 3, 4, 8 or 14 enters the halt state the cycle after dispatch. `halted` then stays high, no further memory strobe is issued, and the PC holds the instruction's address + 4.
- R4: Opcode 8 (add-immediate) writes rs + sign-extended immediate into rt, in 3 cycles after fetch.
- R5: Opcode 14 (xor-immediate) writes rs XOR zero-extended immediate into rt, in 3 cycles. With rs = 39 and immediate 13, rt becomes 42.
- R6: Opcode 4 (branch) sets PC to (instruction address + 4) + 4 × sign-extended immediate, in 3 cycles. Offset 3 at address 0 reaches 16, and negative offsets go backwards.
- R7: Opcode 2 (store-one) writes the value 1 to byte address rs + sign-extended immediate. The write strobe is in the 5th cycle of the routine.
- R8: Opcode 1 (average) writes (rs AND rt) + ((rs XOR rt) >> 1) into rd in 8 cycles. The result is correct even when the true sum would overflow 32 bits, and when rd equals rs or rt.
- R9: Opcode 3 (exchange) swaps rt with the memory word at byte address rs. The write strobe carries the old rt in the 12th cycle of the routine, with an 8-cycle read latency.
- R10: Register 0 reads as zero and writes to it are discarded.
- R11: No control step drives the bus from more than one source.
- R12: `mem_rd` and `mem_wr` are never high together. `mem_addr` is a byte address and `mem_wdata` carries the store data in the write-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for the current strobe |
| mem_rd | output | 1 | Read request strobe, one cycle |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_done` is high |
| mem_done | input | 1 | Read completion flag |
| pc_q | output | 32 | Current program counter |
| halted | output | 1 | High in the halt state |

## Verification
The bench goes after the fetch wait. A sequencer that left `S_F1` early would latch a stale MDR and every write event would shift or carry the wrong data. Signed and unsigned immediates are mixed: an xor with 0x8000 must give 0x00008000, while an add with -2 must give all ones but the LSB, so a swapped extension shows up in stored values. The bench runs a backward branch and an average of two large negative numbers, and a wrong offset scale or a naive add-then-shift would miss. Aliased average destinations, exchanges through register 0, and unknown opcodes check that scratch state, the zero register and the halt path hold.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int FLD_W  = 5;
    localparam int IMM_W  = 16;
    localparam int OP_LSB = 26;
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;
    localparam int RD_LSB = 11;

    localparam logic [OP_W-1:0] OPC_AVG  = 6'd1;
    localparam logic [OP_W-1:0] OPC_ONE  = 6'd2;
    localparam logic [OP_W-1:0] OPC_XCHG = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR   = 6'd4;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OP_W-1:0] OPC_XORI = 6'd14;

    typedef enum logic [4:0] {
        S_F0, S_F1, S_F2, S_F3, S_HALT,
        S_A0, S_A1, S_A2,
        S_X0, S_X1, S_X2,
        S_B0, S_B1, S_B2,
        S_O0, S_O1, S_O2, S_O3, S_O4,
        S_V0, S_V1, S_V2, S_V3, S_V4, S_V5, S_V6, S_V7,
        S_E0, S_E1, S_E2, S_E3, S_E4
    } state_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_XOR, ALU_AND, ALU_SHR1} alu_op_t;
    typedef enum logic [1:0] {SEL_RS, SEL_RT, SEL_RD} rsel_t;

    typedef struct packed {
        logic pc;
        logic mdr;
        logic z;
        logic rf;
        logic y;
        logic c4;
        logic c1;
        logic imms;
        logic immz;
        logic off4;
    } bus_src_t;

    typedef struct packed {
        bus_src_t src;
        logic     pc_in;
        logic     mar_in;
        logic     mdr_in;
        logic     ir_in;
        logic     y_in;
        logic     z_in;
        logic     rf_in;
        alu_op_t  alu;
        rsel_t    sel;
        logic     mem_rd;
        logic     mem_wr;
        logic     wait_mfc;
    } ctrl_t;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && addr != '0) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata = (addr == '0) ? '0 : regs[addr];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic           mem_done,
    output ctrl_t          ctrl,
    output logic           halted
);
    state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_F0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_F0:   state_nx = S_F1;
            S_F1:   state_nx = mem_done ? S_F2 : S_F1;
            S_F2:   state_nx = S_F3;
            S_F3: begin
                case (opcode)
                    OPC_ADDI: state_nx = S_A0;
                    OPC_XORI: state_nx = S_X0;
                    OPC_BR:   state_nx = S_B0;
                    OPC_ONE:  state_nx = S_O0;
                    OPC_AVG:  state_nx = S_V0;
                    OPC_XCHG: state_nx = S_E0;
                    default:  state_nx = S_HALT;
                endcase
            end
            S_HALT: state_nx = S_HALT;
            S_A0:   state_nx = S_A1;
            S_A1:   state_nx = S_A2;
            S_X0:   state_nx = S_X1;
            S_X1:   state_nx = S_X2;
            S_B0:   state_nx = S_B1;
            S_B1:   state_nx = S_B2;
            S_O0:   state_nx = S_O1;
            S_O1:   state_nx = S_O2;
            S_O2:   state_nx = S_O3;
            S_O3:   state_nx = S_O4;
            S_V0:   state_nx = S_V1;
            S_V1:   state_nx = S_V2;
            S_V2:   state_nx = S_V3;
            S_V3:   state_nx = S_V4;
            S_V4:   state_nx = S_V5;
            S_V5:   state_nx = S_V6;
            S_V6:   state_nx = S_V7;
            S_E0:   state_nx = S_E1;
            S_E1:   state_nx = mem_done ? S_E2 : S_E1;
            S_E2:   state_nx = S_E3;
            S_E3:   state_nx = S_E4;
            S_A2, S_X2, S_B2, S_O4, S_V7, S_E4: state_nx = S_F0;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (state)
            S_F0: begin ctrl.src.pc = 1'b1; ctrl.mar_in = 1'b1; ctrl.mem_rd = 1'b1; ctrl.y_in = 1'b1; end
            S_F1: begin ctrl.src.c4 = 1'b1; ctrl.alu = ALU_ADD; ctrl.z_in = 1'b1; ctrl.wait_mfc = 1'b1; end
            S_F2: begin ctrl.src.mdr = 1'b1; ctrl.ir_in = 1'b1; end
            S_F3: begin ctrl.src.z = 1'b1; ctrl.pc_in = 1'b1; end
            S_HALT: ctrl = '0;
            S_A0, S_X0, S_O0, S_V0: begin ctrl.src.rf = 1'b1; ctrl.sel = SEL_RS; ctrl.y_in = 1'b1; end
            S_A1, S_O1: begin ctrl.src.imms = 1'b1; ctrl.alu = ALU_ADD; ctrl.z_in = 1'b1; end
            S_X1: begin ctrl.src.immz = 1'b1; ctrl.alu = ALU_XOR; ctrl.z_in = 1'b1; end
            S_A2, S_X2: begin ctrl.src.z = 1'b1; ctrl.sel = SEL_RT; ctrl.rf_in = 1'b1; end
            S_B0: begin ctrl.src.pc = 1'b1; ctrl.y_in = 1'b1; end
            S_B1: begin ctrl.src.off4 = 1'b1; ctrl.alu = ALU_ADD; ctrl.z_in = 1'b1; end
            S_B2: begin ctrl.src.z = 1'b1; ctrl.pc_in = 1'b1; end
            S_O2: begin ctrl.src.z = 1'b1; ctrl.mar_in = 1'b1; end
            S_O3: begin ctrl.src.c1 = 1'b1; ctrl.mdr_in = 1'b1; end
            S_O4, S_E4: ctrl.mem_wr = 1'b1;
            S_V1: begin ctrl.src.rf = 1'b1; ctrl.sel = SEL_RT; ctrl.alu = ALU_XOR; ctrl.z_in = 1'b1; end
            S_V2: begin ctrl.src.z = 1'b1; ctrl.alu = ALU_SHR1; ctrl.z_in = 1'b1; end
            S_V3: begin ctrl.src.z = 1'b1; ctrl.mdr_in = 1'b1; end
            S_V4: begin ctrl.src.rf = 1'b1; ctrl.sel = SEL_RT; ctrl.alu = ALU_AND; ctrl.z_in = 1'b1; end
            S_V5: begin ctrl.src.z = 1'b1; ctrl.y_in = 1'b1; end
            S_V6: begin ctrl.src.mdr = 1'b1; ctrl.alu = ALU_ADD; ctrl.z_in = 1'b1; end
            S_V7: begin ctrl.src.z = 1'b1; ctrl.sel = SEL_RD; ctrl.rf_in = 1'b1; end
            S_E0: begin ctrl.src.rf = 1'b1; ctrl.sel = SEL_RS; ctrl.mar_in = 1'b1; ctrl.mem_rd = 1'b1; end
            S_E1: begin ctrl.src.rf = 1'b1; ctrl.sel = SEL_RT; ctrl.y_in = 1'b1; ctrl.wait_mfc = 1'b1; end
            S_E2: begin ctrl.src.mdr = 1'b1; ctrl.sel = SEL_RT; ctrl.rf_in = 1'b1; end
            S_E3: begin ctrl.src.y = 1'b1; ctrl.mdr_in = 1'b1; end
        endcase
    end

    assign halted = (state == S_HALT);
endmodule

// File: rtl/cpu_dpath.sv
module cpu_dpath
    import cpu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl,
    input  logic            mem_done,
    input  logic [W-1:0]    mem_rdata,
    output logic [OP_W-1:0] opcode,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [W-1:0]    pc_q
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] pc, mar, mdr, ir, y, z;
    logic [W-1:0] bus, alu_out, imm_s, imm_z, off4, rf_rdata;
    logic [AW-1:0] rf_addr;

    assign imm_s = {{(W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    assign imm_z = {{(W-IMM_W){1'b0}}, ir[IMM_W-1:0]};
    assign off4  = imm_s << 2;

    always_comb begin
        unique case (ctrl.sel)
            SEL_RT:  rf_addr = ir[RT_LSB +: AW];
            SEL_RD:  rf_addr = ir[RD_LSB +: AW];
            default: rf_addr = ir[RS_LSB +: AW];
        endcase
    end

    always_comb begin
        bus = '0;
        if (ctrl.src.pc)   bus = bus | pc;
        if (ctrl.src.mdr)  bus = bus | mdr;
        if (ctrl.src.z)    bus = bus | z;
        if (ctrl.src.rf)   bus = bus | rf_rdata;
        if (ctrl.src.y)    bus = bus | y;
        if (ctrl.src.c4)   bus = bus | W'(4);
        if (ctrl.src.c1)   bus = bus | W'(1);
        if (ctrl.src.imms) bus = bus | imm_s;
        if (ctrl.src.immz) bus = bus | imm_z;
        if (ctrl.src.off4) bus = bus | off4;
    end

    always_comb begin
        unique case (ctrl.alu)
            ALU_ADD:  alu_out = y + bus;
            ALU_XOR:  alu_out = y ^ bus;
            ALU_AND:  alu_out = y & bus;
            ALU_SHR1: alu_out = bus >> 1;
        endcase
    end

    cpu_regfile #(.W(W), .NREG(NREG), .AW(AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.rf_in),
        .addr  (rf_addr),
        .wdata (bus),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; mdr <= '0; ir <= '0; y <= '0; z <= '0;
        end else begin
            if (ctrl.pc_in)  pc  <= bus;
            if (ctrl.mar_in) mar <= bus;
            if (ctrl.ir_in)  ir  <= bus;
            if (ctrl.y_in)   y   <= bus;
            if (ctrl.z_in)   z   <= alu_out;
            if (ctrl.wait_mfc && mem_done) mdr <= mem_rdata;
            else if (ctrl.mdr_in)          mdr <= bus;
        end
    end

    assign opcode    = ir[OP_LSB +: OP_W];
    assign mem_addr  = ctrl.mar_in ? bus : mar;
    assign mem_wdata = mdr;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign pc_q      = pc;
endmodule

// File: rtl/cpu_top.sv
module cpu_top
    import cpu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_done,
    output logic [W-1:0] pc_q,
    output logic         halted
);
    ctrl_t           ctrl_w;
    logic [OP_W-1:0] opcode_w;

    cpu_ctrl #(.OPW(OP_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode_w),
        .mem_done (mem_done),
        .ctrl     (ctrl_w),
        .halted   (halted)
    );

    cpu_dpath #(.W(W), .NREG(NREG)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_w),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .opcode    (opcode_w),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc_q      (pc_q)
    );
endmodule

// File: rtl/cpu_top_chk.sv
module cpu_top_chk
    import cpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input logic         clk,
    input logic         rst_n,
    input ctrl_t        ctrl_w,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic         mem_done,
    input logic [W-1:0] pc_q,
    input logic         halted
);
    // R11
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_w.src));

    // R12
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R3
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w.wait_mfc && !mem_done) |=> $stable(pc_q));

    // R12
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
endmodule

bind cpu_top cpu_top_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_w   (ctrl_w),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_done (mem_done),
    .pc_q     (pc_q),
    .halted   (halted)
);

// File: tb/cpu_top_test.sv
module cpu_top_test;
    localparam int LAT   = 8;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, pc_q;
    logic        mem_rd, mem_wr, halted;
    logic [31:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cpu_top uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .pc_q(pc_q), .halted(halted)
    );

    // behavioural memory with a fixed read latency
    logic [31:0] mem  [WORDS];
    logic [31:0] rmem [WORDS];
    logic [31:0] rregs [32];
    int lat_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt  <= 0;
            mem_done <= 1'b0;
        end else if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:2]];
            lat_cnt   <= 1;
            mem_done  <= 1'b0;
        end else if (lat_cnt != 0 && !mem_done) begin
            if (lat_cnt == LAT - 1) mem_done <= 1'b1;
            lat_cnt <= lat_cnt + 1;
        end
        if (rst_n && mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    typedef struct {
        int          cyc;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } wr_t;
    wr_t exp_q[$];
    int          exp_halt;
    logic [31:0] exp_pc;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_r(input int op, input int rs, input int rt, input int rd);
        return {op[5:0], rs[4:0], rt[4:0], rd[4:0], 11'b0};
    endfunction

    task automatic clear_all();
        for (int i = 0; i < WORDS; i++) begin mem[i] = '0; rmem[i] = '0; end
        for (int i = 0; i < 32; i++) rregs[i] = '0;
    endtask

    task automatic put(input int addr, input logic [31:0] w);
        mem[addr/4]  = w;
        rmem[addr/4] = w;
    endtask

    // instruction-level reference with cycle accounting
    task automatic model();
        logic [31:0] pc, ir, sx, zx, a, b, tmp, ea;
        int t, e, rs, rt, rd;
        pc = '0; t = 0;
        exp_q.delete();
        exp_halt = -1;
        for (int n = 0; n < 400; n++) begin
            ir = rmem[pc[7:2]];
            rs = int'(ir[25:21]); rt = int'(ir[20:16]); rd = int'(ir[15:11]);
            sx = {{16{ir[15]}}, ir[15:0]};
            zx = {16'h0, ir[15:0]};
            pc = pc + 4;
            e  = t + 11;
            case (int'(ir[31:26]))
                8:  begin rregs[rt] = rregs[rs] + sx; t = e + 3; end
                14: begin rregs[rt] = rregs[rs] ^ zx; t = e + 3; end
                4:  begin pc = pc + (sx * 4); t = e + 3; end
                2: begin
                    ea = rregs[rs] + sx;
                    exp_q.push_back('{e + 4, ea, 32'd1, "R7"});
                    rmem[ea[7:2]] = 32'd1;
                    t = e + 5;
                end
                1: begin
                    a = rregs[rs]; b = rregs[rt];
                    rregs[rd] = (a & b) + ((a ^ b) >> 1);
                    t = e + 8;
                end
                3: begin
                    ea  = rregs[rs];
                    tmp = rmem[ea[7:2]];
                    exp_q.push_back('{e + 11, ea, rregs[rt], "R9"});
                    rmem[ea[7:2]] = rregs[rt];
                    rregs[rt] = tmp;
                    t = e + 12;
                end
                default: begin exp_halt = e; exp_pc = pc; break; end
            endcase
            rregs[0] = '0;
        end
    endtask

    task automatic run_prog(input string req);
        bit mem_ok;
        model();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int cyc = 0; cyc <= exp_halt + 6; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 0)
                chk(mem_rd && mem_addr == 0 && !halted && pc_q == 0, "R1", "reset fetch state",
                    {halted, mem_rd, pc_q[29:0]}, 32'h4000_0000);
            if (mem_rd && mem_wr) chk(0, "R12", "read and write together", 32'd1, 32'd0);
            if (mem_wr) begin
                if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                    chk(mem_addr == exp_q[0].addr, {req, " ", exp_q[0].tag, " R12"}, "write address",
                        mem_addr, exp_q[0].addr);
                    chk(mem_wdata == exp_q[0].data, {req, " ", exp_q[0].tag}, "write data",
                        mem_wdata, exp_q[0].data);
                    void'(exp_q.pop_front());
                end else begin
                    chk(0, {req, " R2"}, "write at unexpected cycle", mem_addr, 32'hFFFF_FFFF);
                end
            end else if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                chk(0, {req, " R2 ", exp_q[0].tag}, "missing write", 32'h0, exp_q[0].data);
                void'(exp_q.pop_front());
            end
            if (cyc == exp_halt)
                chk(halted, {req, " R2 R3"}, "halt at expected cycle", 32'(halted), 32'd1);
            else if (cyc < exp_halt && halted)
                chk(0, {req, " R3"}, "early halt", 32'(cyc), 32'(exp_halt));
        end
        chk(halted, {req, " R3"}, "halt held", 32'(halted), 32'd1);
        chk(pc_q == exp_pc, {req, " R3"}, "final pc", pc_q, exp_pc);
        chk(exp_q.size() == 0, req, "writes outstanding", 32'(exp_q.size()), 32'd0);
        mem_ok = 1'b1;
        for (int i = 0; i < WORDS; i++) if (mem[i] !== rmem[i]) mem_ok = 1'b0;
        chk(mem_ok, req, "final memory image", 32'(mem_ok), 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // R4 R5 R9 R10: xor-immediate, add-immediate, exchange both ways, zero register
        clear_all();
        put(0,  enc_i(8, 0, 9, 39));
        put(4,  enc_i(14, 9, 10, 13));
        put(8,  enc_i(8, 0, 11, 100));
        put(12, enc_r(3, 11, 10, 0));
        put(16, enc_i(14, 0, 16, 16'h8000));
        put(20, enc_i(8, 0, 12, 104));
        put(24, enc_r(3, 12, 16, 0));
        put(28, enc_r(3, 11, 10, 0));
        put(32, enc_i(8, 0, 0, 5));
        put(36, enc_i(8, 0, 13, 108));
        put(40, enc_r(3, 13, 0, 0));
        put(100, 32'd7);
        put(108, 32'h1234_5678);
        run_prog("R4 R5 R9 R10");
        chk(mem[25] == 32'd7 && rmem[25] == 32'd7, "R9", "swap restored", mem[25], 32'd7);
        chk(mem[26] == 32'h0000_8000, "R5", "zero-extended xor", mem[26], 32'h0000_8000);
        chk(mem[27] == 32'd0, "R10", "register 0 stored", mem[27], 32'd0);

        // R7: store-one with positive and negative offsets
        clear_all();
        put(0,  enc_i(8, 0, 1, 4));
        put(4,  enc_i(2, 1, 0, 40));
        put(8,  enc_i(8, 0, 2, 60));
        put(12, enc_i(2, 2, 0, 16'hFFF8));
        put(44, 32'd42);
        run_prog("R7");
        chk(mem[11] == 32'd1 && mem[13] == 32'd1, "R7", "store-one targets", mem[11] + mem[13], 32'd2);

        // R6: forward branch
        clear_all();
        put(0, 32'h1000_0003);
        run_prog("R6");
        chk(pc_q == 32'd20, "R6", "forward branch pc", pc_q, 32'd20);

        // R6: backward branch then store
        clear_all();
        put(0,  enc_i(4, 0, 0, 3));
        put(16, enc_i(4, 0, 0, 16'hFFFD));
        put(8,  enc_i(2, 0, 0, 60));
        run_prog("R6 R7");
        chk(pc_q == 32'd16, "R6", "backward branch pc", pc_q, 32'd16);

        // R8: average, overflow-prone operands, aliased destination
        clear_all();
        put(0,  enc_i(8, 0, 9, 64));
        put(4,  enc_i(8, 0, 10, 32));
        put(8,  enc_i(8, 0, 8, 42));
        put(12, enc_r(1, 9, 10, 8));
        put(16, enc_i(8, 0, 12, 200));
        put(20, enc_r(3, 12, 8, 0));
        put(24, enc_i(8, 0, 13, 16'hFFFE));
        put(28, enc_i(8, 0, 14, 16'hFFFC));
        put(32, enc_r(1, 13, 14, 15));
        put(36, enc_i(8, 0, 17, 204));
        put(40, enc_r(3, 17, 15, 0));
        put(44, enc_r(1, 9, 10, 9));
        put(48, enc_i(8, 0, 18, 208));
        put(52, enc_r(3, 18, 9, 0));
        run_prog("R8 R4");
        chk(mem[50] == 32'd48, "R8", "average 64,32", mem[50], 32'd48);
        chk(mem[51] == 32'hFFFF_FFFD, "R8", "average of large values", mem[51], 32'hFFFF_FFFD);
        chk(mem[52] == 32'd48, "R8", "aliased destination", mem[52], 32'd48);

        // R3: unknown opcode halts
        clear_all();
        put(0, enc_i(63, 0, 0, 0));
        run_prog("R3");
        chk(pc_q == 32'd4, "R3", "pc after undecoded op", pc_q, 32'd4);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule